// File: doc/BRIEF.md
# Dual-Buffer Instruction Prefetch Queue

This block sits between an instruction memory port and a variable-length decoder. It keeps two 16-byte line slots, fills them in turn from a line-request/line-valid memory handshake, and shows the decoder a byte window at the head of the stream. The window is at most three bytes, which is enough for the opcode and addressing-mode bytes that a first decode stage inspects. The decoder reports how many of those bytes it used each cycle. A longer instruction is taken over several cycles by consuming the window again.

Fetching does not depend on the decoder. While either slot is empty and no line is in flight, a new line is requested, so the queue fills up even when decode is stalled. The head can sit near the end of one slot while the next slot already holds the following line, and the window then runs across the seam without a gap.

A taken branch drives the flush input together with the target address. Flush empties both slots and restarts fetching at the target's line-aligned address. The bytes of that first line that lie below the target are never presented. A line that was requested before the flush and returns later is thrown away.

Top module: `pfq_prefetch_queue`

## Requirements
- R1: In reset and in the first cycle after it, the window count is 0. In that first cycle `mem_req` is high with `mem_addr` equal to the reset address (0 by default).
- R2: At most one line request is outstanding at a time, and at most 32 bytes (two lines) are held. No request is made while a request is in flight.
- R3: Outside a flush cycle, `mem_req` is high exactly when no request is outstanding and fewer than two lines are held. Each granted request advances the line address by 16. A request is taken as accepted in the cycle it is high.
- R4: With the consume count held at 0, requests go on until both slots are full, and then they stop.
- R5: `win_cnt` equals the smaller of the held byte count and 3. Window byte j (bits 8j+7..8j) is stream byte j from the head. Window bytes at positions j >= `win_cnt` read 0.
- R6: When fewer than three bytes remain in the head line, the following window bytes come from the next held line in address order.
- R7: A consume count from 1 to `win_cnt` removes that many bytes from the head. A count of 0, or one larger than `win_cnt`, leaves the stream unchanged.
- R8: In a flush cycle, `mem_req` is low and the consume count is ignored. In the next cycle no bytes are held. The next request goes to the flush address with its low four bits cleared.
- R9: After a flush, the first byte presented is the byte at the flush address. Lower bytes of that line are skipped.
- R10: A line that returns for a request made before a flush, including one that returns in the flush cycle itself, is discarded. No new request is issued until that line has returned.
- R11: Byte k of `mem_line` (bits 8k+7..8k) is the byte at line address + k, and bytes are presented in increasing address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Taken-branch redirect; empties the queue |
| flush_addr | input | 32 | Byte address of the branch target |
| mem_req | output | 1 | Line request, accepted in the cycle it is high |
| mem_addr | output | 32 | 16-byte-aligned address of the requested line |
| mem_valid | input | 1 | Returned line is present on `mem_line` |
| mem_line | input | 128 | Returned line, byte k at bits 8k+7..8k |
| win_cnt | output | 2 | Number of valid window bytes (0 to 3) |
| win_bytes | output | 24 | Window, byte j at bits 8j+7..8j |
| cons_cnt | input | 2 | Bytes taken by the decoder this cycle |

## Verification
The hardest case to reach from the ports is a flush that lands while a line is in flight. Two timings matter: the flush arriving in the very cycle the stale line comes back, and the flush arriving earlier so that the stale line returns later on its own. The bench's memory answers with a random latency of zero to four cycles. It raises flush far more often in cycles where it is presenting a returning line, so both timings occur many times. A reference model of the byte stream shows at once if any stale or skipped byte leaks through. An opening phase with no consumption drives the queue to full, and random consume counts, some larger than the window, move the head across the line seam at every offset.

// File: rtl/pfq_pkg.sv
`timescale 1ns/1ps
package pfq_pkg;

    localparam int PFQ_ADDR_W     = 32;
    localparam int PFQ_LINE_BYTES = 16;
    localparam int PFQ_WIN_BYTES  = 3;

    // Request tracking: no request, request in flight, in-flight request made stale by a flush
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_LIVE  = 2'd1,
        FS_STALE = 2'd2
    } fetch_st_e;

    function automatic int pfq_off_w(input int line_bytes);
        return $clog2(line_bytes);
    endfunction

    function automatic int pfq_cnt_w(input int win_bytes);
        return $clog2(win_bytes + 1);
    endfunction

endpackage

// File: rtl/pfq_fetch_ctl.sv
`timescale 1ns/1ps
module pfq_fetch_ctl
    import pfq_pkg::*;
#(
    parameter int ADDR_W     = PFQ_ADDR_W,
    parameter int LINE_BYTES = PFQ_LINE_BYTES,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              mem_valid,
    input  logic              slot_free,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              fill_en,
    output logic              fill_sel
);
    localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'(LINE_BYTES - 1);
    localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);

    fetch_st_e         st_q;
    logic [ADDR_W-1:0] line_addr_q;
    logic              sel_q;

    assign mem_req  = (st_q == FS_IDLE) && !flush && slot_free;
    assign fill_en  = (st_q == FS_LIVE) && mem_valid && !flush;
    assign mem_addr = line_addr_q;
    assign fill_sel = sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= FS_IDLE;
            line_addr_q <= RESET_ADDR & ~LOW_MASK;
            sel_q       <= 1'b0;
        end else if (flush) begin
            line_addr_q <= flush_addr & ~LOW_MASK;
            sel_q       <= 1'b0;
            if (st_q != FS_IDLE && !mem_valid) st_q <= FS_STALE;
            else                               st_q <= FS_IDLE;
        end else begin
            unique case (st_q)
                FS_IDLE: if (mem_req) begin
                    st_q        <= FS_LIVE;
                    line_addr_q <= line_addr_q + LINE_STEP;
                end
                FS_LIVE: if (mem_valid) begin
                    st_q  <= FS_IDLE;
                    sel_q <= ~sel_q;
                end
                FS_STALE: if (mem_valid) st_q <= FS_IDLE;
                default: st_q <= FS_IDLE;
            endcase
        end
    end

    assert_req_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ((mem_addr & LOW_MASK) == '0));

endmodule

// File: rtl/pfq_line_store.sv
`timescale 1ns/1ps
module pfq_line_store
    import pfq_pkg::*;
#(
    parameter int LINE_BYTES = PFQ_LINE_BYTES
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flush,
    input  logic                      fill_en,
    input  logic                      fill_sel,
    input  logic [LINE_BYTES*8-1:0]   fill_line,
    input  logic                      drain_en,
    input  logic                      drain_sel,
    output logic [1:0]                slot_v,
    output logic [2*LINE_BYTES*8-1:0] lines_flat
);
    localparam int LINE_W = LINE_BYTES * 8;

    for (genvar g = 0; g < 2; g++) begin : g_slot
        logic              v_q;
        logic [LINE_W-1:0] d_q;

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                v_q <= 1'b0;
            end else if (fill_en && (fill_sel == 1'(g))) begin
                v_q <= 1'b1;
            end else if (drain_en && (drain_sel == 1'(g))) begin
                v_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                d_q <= '0;
            end else if (fill_en && (fill_sel == 1'(g))) begin
                d_q <= fill_line;
            end
        end

        assign slot_v[g] = v_q;
        assign lines_flat[g*LINE_W +: LINE_W] = d_q;
    end

    assert_fill_into_free_R2: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> !slot_v[fill_sel]);

    assert_drain_held_R7: assert property (@(posedge clk) disable iff (rst)
        drain_en |-> slot_v[drain_sel]);

endmodule

// File: rtl/pfq_read_ptr.sv
`timescale 1ns/1ps
module pfq_read_ptr
    import pfq_pkg::*;
#(
    parameter int LINE_BYTES = PFQ_LINE_BYTES,
    parameter int WIN_BYTES  = PFQ_WIN_BYTES,
    parameter int RESET_OFF  = 0,
    localparam int OFF_W     = pfq_off_w(LINE_BYTES),
    localparam int CNT_W     = pfq_cnt_w(WIN_BYTES),
    localparam int AVAIL_W   = $clog2(2 * LINE_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [OFF_W-1:0]   flush_off,
    input  logic [1:0]         slot_v,
    input  logic [CNT_W-1:0]   cons_cnt,
    output logic               rd_sel,
    output logic [OFF_W-1:0]   rd_off,
    output logic [AVAIL_W-1:0] avail,
    output logic [CNT_W-1:0]   win_cnt,
    output logic               drain_en
);
    localparam logic [AVAIL_W-1:0] LB_A  = AVAIL_W'(LINE_BYTES);
    localparam logic [AVAIL_W-1:0] WIN_A = AVAIL_W'(WIN_BYTES);

    logic             sel_q;
    logic [OFF_W-1:0] off_q;
    logic             head_v, tail_v, take;
    logic [OFF_W:0]   sum;

    assign head_v = slot_v[sel_q];
    assign tail_v = slot_v[~sel_q];

    always_comb begin
        avail = '0;
        if (head_v) begin
            avail = LB_A - AVAIL_W'(off_q);
            if (tail_v) avail = avail + LB_A;
        end
    end

    assign win_cnt  = (avail >= WIN_A) ? CNT_W'(WIN_BYTES) : avail[CNT_W-1:0];
    assign take     = !flush && (cons_cnt != '0) && (cons_cnt <= win_cnt);
    assign sum      = {1'b0, off_q} + (OFF_W+1)'(cons_cnt);
    assign drain_en = take && sum[OFF_W];
    assign rd_sel   = sel_q;
    assign rd_off   = off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            off_q <= OFF_W'(RESET_OFF);
        end else if (flush) begin
            sel_q <= 1'b0;
            off_q <= flush_off;
        end else if (take) begin
            off_q <= sum[OFF_W-1:0];
            if (sum[OFF_W]) sel_q <= ~sel_q;
        end
    end

    assert_avail_cap_R2: assert property (@(posedge clk) disable iff (rst)
        avail <= AVAIL_W'(2 * LINE_BYTES));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (avail == '0));

    assert_ignore_consume_R7: assert property (@(posedge clk) disable iff (rst)
        (!flush && (cons_cnt > win_cnt)) |=> (rd_off == $past(rd_off) && rd_sel == $past(rd_sel)));

endmodule

// File: rtl/pfq_window.sv
`timescale 1ns/1ps
module pfq_window
    import pfq_pkg::*;
#(
    parameter int LINE_BYTES = PFQ_LINE_BYTES,
    parameter int WIN_BYTES  = PFQ_WIN_BYTES,
    localparam int OFF_W     = pfq_off_w(LINE_BYTES),
    localparam int CNT_W     = pfq_cnt_w(WIN_BYTES)
) (
    input  logic [2*LINE_BYTES*8-1:0] lines_flat,
    input  logic                      rd_sel,
    input  logic [OFF_W-1:0]          rd_off,
    input  logic [CNT_W-1:0]          win_cnt,
    output logic [WIN_BYTES*8-1:0]    win_bytes
);
    // Each window byte picks its slot from the carry out of head offset + j
    for (genvar j = 0; j < WIN_BYTES; j++) begin : g_byte
        logic [OFF_W:0] idx;
        logic [OFF_W:0] pos;

        assign idx = {1'b0, rd_off} + (OFF_W+1)'(j);
        assign pos = {rd_sel ^ idx[OFF_W], idx[OFF_W-1:0]};
        assign win_bytes[j*8 +: 8] = (CNT_W'(j) < win_cnt) ? lines_flat[pos*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/pfq_prefetch_queue.sv
`timescale 1ns/1ps
module pfq_prefetch_queue
    import pfq_pkg::*;
#(
    parameter int ADDR_W     = PFQ_ADDR_W,
    parameter int LINE_BYTES = PFQ_LINE_BYTES,
    parameter int WIN_BYTES  = PFQ_WIN_BYTES,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int OFF_W     = pfq_off_w(LINE_BYTES),
    localparam int CNT_W     = pfq_cnt_w(WIN_BYTES),
    localparam int AVAIL_W   = $clog2(2 * LINE_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic [ADDR_W-1:0]       flush_addr,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_valid,
    input  logic [LINE_BYTES*8-1:0] mem_line,
    output logic [CNT_W-1:0]        win_cnt,
    output logic [WIN_BYTES*8-1:0]  win_bytes,
    input  logic [CNT_W-1:0]        cons_cnt
);
    logic                      fill_en, fill_sel, drain_en, rd_sel;
    logic [1:0]                slot_v;
    logic [2*LINE_BYTES*8-1:0] lines_flat;
    logic [OFF_W-1:0]          rd_off;
    logic [AVAIL_W-1:0]        avail;
    logic                      slot_free;

    assign slot_free = !slot_v[fill_sel];

    pfq_fetch_ctl #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .RESET_ADDR(RESET_ADDR)
    ) u_fetch (
        .clk(clk), .rst(rst), .flush(flush), .flush_addr(flush_addr),
        .mem_valid(mem_valid), .slot_free(slot_free),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .fill_en(fill_en), .fill_sel(fill_sel)
    );

    pfq_line_store #(.LINE_BYTES(LINE_BYTES)) u_store (
        .clk(clk), .rst(rst), .flush(flush),
        .fill_en(fill_en), .fill_sel(fill_sel), .fill_line(mem_line),
        .drain_en(drain_en), .drain_sel(rd_sel),
        .slot_v(slot_v), .lines_flat(lines_flat)
    );

    pfq_read_ptr #(
        .LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES),
        .RESET_OFF(int'(RESET_ADDR[OFF_W-1:0]))
    ) u_rdptr (
        .clk(clk), .rst(rst), .flush(flush), .flush_off(flush_addr[OFF_W-1:0]),
        .slot_v(slot_v), .cons_cnt(cons_cnt),
        .rd_sel(rd_sel), .rd_off(rd_off), .avail(avail),
        .win_cnt(win_cnt), .drain_en(drain_en)
    );

    pfq_window #(.LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES)) u_win (
        .lines_flat(lines_flat), .rd_sel(rd_sel), .rd_off(rd_off),
        .win_cnt(win_cnt), .win_bytes(win_bytes)
    );

endmodule

// File: tb/pfq_prefetch_queue_tb.sv
`timescale 1ns/1ps
module pfq_prefetch_queue_tb;
    localparam int AW = 32, LB = 16, WIN = 3, CW = 2;
    localparam int NCYC = 4000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst, flush, mem_valid, mem_req;
    logic [AW-1:0]   flush_addr, mem_addr;
    logic [LB*8-1:0] mem_line;
    logic [CW-1:0]   win_cnt, cons_cnt;
    logic [WIN*8-1:0] win_bytes;

    pfq_prefetch_queue u_dut (
        .clk(clk), .rst(rst), .flush(flush), .flush_addr(flush_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_line(mem_line), .win_cnt(win_cnt), .win_bytes(win_bytes),
        .cons_cnt(cons_cnt)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0]  exp_q[$];
    int          line_rem[$];
    bit          line_skp[$];
    int unsigned next_addr;
    int          skip, epoch;
    bit          after_flush, ign_prev;
    bit          m_out;
    int          m_cnt, m_epoch;
    int unsigned m_addr;

    function automatic logic [7:0] mbyte(input int unsigned a);
        return 8'((a * 37) ^ (a >> 7) ^ 32'h5A);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, NCYC);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; flush = 1'b0; flush_addr = '0; mem_valid = 1'b0;
        mem_line = '0; cons_cnt = '0;
        next_addr = 0; skip = 0; epoch = 0; after_flush = 0; ign_prev = 0;
        m_out = 0; m_cnt = 0; m_epoch = 0; m_addr = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #2 chk(win_cnt == 0, "R1", "win_cnt in reset", win_cnt, 0);
        end
        @(negedge clk);
        rst = 1'b0;

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            int  ecnt, n;
            bit  exp_req, s_req, fl;
            int unsigned s_addr;
            string tag;
            if (cyc != 0) @(negedge clk);
            // drive
            mem_valid = m_out && (m_cnt == 0);
            if (mem_valid)
                for (int k = 0; k < LB; k++) mem_line[k*8 +: 8] = mbyte(m_addr + k);
            else mem_line = '0;
            if (cyc < 40) begin
                cons_cnt = '0;
                flush = 1'b0;
            end else begin
                cons_cnt = CW'($urandom_range(0, 3));
                flush = mem_valid ? ($urandom_range(0, 4) == 0) : ($urandom_range(0, 29) == 0);
                flush_addr = $urandom & 32'h0000_FFFF;
            end
            #2;
            ecnt = (exp_q.size() < WIN) ? exp_q.size() : WIN;
            tag = (cyc == 0) ? "R1" : ign_prev ? "R7" : "R5";
            chk(win_cnt == CW'(ecnt), tag, "win_cnt", win_cnt, ecnt);
            for (int j = 0; j < WIN; j++) begin
                logic [7:0] eb;
                eb = (j < ecnt) ? exp_q[j] : 8'h00;
                if (j >= ecnt) tag = "R5";
                else if (j >= line_rem[0]) tag = "R6";
                else if (line_skp[0]) tag = "R9";
                else tag = "R11";
                chk(win_bytes[j*8 +: 8] == eb, tag, $sformatf("win byte %0d", j),
                    win_bytes[j*8 +: 8], eb);
            end
            exp_req = !flush && !m_out && (line_rem.size() < 2);
            if (cyc == 0) tag = "R1";
            else if (flush) tag = "R8";
            else if (m_out && m_epoch != epoch) tag = "R10";
            else if (line_rem.size() == 2) tag = (cyc < 40) ? "R4" : "R2";
            else if (m_out) tag = "R2";
            else tag = "R3";
            chk(mem_req == exp_req, tag, "mem_req", mem_req, exp_req);
            if (mem_req && exp_req) begin
                tag = (cyc == 0) ? "R1" : after_flush ? "R8" : "R3";
                chk(mem_addr == next_addr, tag, "mem_addr", mem_addr, next_addr);
            end
            s_req = mem_req; s_addr = mem_addr;
            fl = flush; n = int'(cons_cnt);

            @(posedge clk);
            // reference model update
            if (fl) begin
                exp_q.delete(); line_rem.delete(); line_skp.delete();
                skip = int'(flush_addr % LB);
                next_addr = flush_addr - skip;
                epoch++;
                after_flush = 1;
                ign_prev = 0;
            end else begin
                ign_prev = (n > ecnt);
                if (n != 0 && n <= ecnt) begin
                    for (int i = 0; i < n; i++) begin
                        void'(exp_q.pop_front());
                        line_rem[0] = line_rem[0] - 1;
                        if (line_rem[0] == 0) begin
                            void'(line_rem.pop_front());
                            void'(line_skp.pop_front());
                        end
                    end
                end
                if (mem_valid && m_epoch == epoch) begin
                    for (int k = skip; k < LB; k++) exp_q.push_back(mbyte(m_addr + k));
                    line_rem.push_back(LB - skip);
                    line_skp.push_back(skip != 0);
                    skip = 0;
                end
            end
            if (mem_valid) m_out = 0;
            else if (m_out) m_cnt--;
            if (s_req && !fl) begin
                m_out = 1;
                m_cnt = $urandom_range(0, 4);
                m_addr = next_addr;
                m_epoch = epoch;
                next_addr += LB;
                after_flush = 0;
            end
            if (s_req && s_addr == 32'hFFFF_FFFF) $display("unreachable");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule